// File: doc/BRIEF.md
# Wake Event Collector

This block gathers a set of wake-up sources (external pins or on-chip signals) and turns them into per-source status bits plus one request that asks the power supply to come on. Each source position is given one of three behaviours at build time: a captured event that can wake the system, a level that is passed straight through and can wake the system, or a captured event that is only reported and never wakes the system. Positions may also be left unused.

Every input passes through a synchronizer before use. Captured sources detect a configurable edge (rising or falling, chosen per source) and hold a sticky bit until a read strobe clears it; an edge arriving in the very cycle of the clearing read wins, so no event slips through. Level sources report the synchronized input and are cleared only when the source itself drops. The power-on request is the registered OR of the enabled wake-capable bits.

Top module: `wake_event_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with all inputs low, every status bit and the power-on request read 0.
- R2: The class of event i is held in CLASS_MAP bits [2i+1:2i]: 1 = captured and wake-capable, 2 = level, 3 = captured report-only, 0 = unused. A captured event's status bit becomes 1 three clock edges after its input changes (two synchronizer stages, one latch) and stays 1 after the input returns.
- R3: A one-cycle rd_stb clears every captured status bit at the next clock edge when no new edge is detected in that cycle.
- R4: When a detected edge and rd_stb occur in the same cycle, that event's status bit stays 1.
- R5: A level event's status bit equals its synchronized input (two edges of delay) and is not changed by rd_stb.
- R6: A class 3 event never causes pwr_on_req to be 1.
- R7: cfg_rise[i] = 1 makes event i capture a rising edge; cfg_rise[i] = 0 makes it capture a falling edge, and the opposite edge is ignored.
- R8: pwr_on_req is 1 one clock edge after any status bit of class 1 or class 2 with its cfg_pwr_en bit set is 1, and 0 one edge after none is.
- R9: An event with cfg_pwr_en[i] = 0 still reports status but does not drive pwr_on_req.
- R10: Status bit i corresponds to event i; an unused position (class 0) always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_in | input | NUM_EVT | Raw wake sources, one bit per event |
| cfg_rise | input | NUM_EVT | Per-event edge select: 1 rising, 0 falling |
| cfg_pwr_en | input | NUM_EVT | Per-event enable into the power-on OR |
| rd_stb | input | 1 | One-cycle status read strobe; clears captured bits |
| status | output | NUM_EVT | Per-event status |
| pwr_on_req | output | 1 | Registered power-on request |

## Verification
The hardest case to reach from the ports is an edge detected in exactly the cycle in which the read strobe is high, because the detection cycle sits two synchronizer edges behind the input change. The bench counts those stages: it changes the input on a falling clock edge, waits two more falling edges, and raises rd_stb for the single cycle in which the edge is seen, then confirms the bit survived the read while a later plain read clears it.

// File: rtl/wake_pkg.sv
package wake_pkg;
  typedef enum logic [1:0] {
    EVT_UNUSED     = 2'd0,
    EVT_LATCH_PWR  = 2'd1,
    EVT_LEVEL      = 2'd2,
    EVT_LATCH_ONLY = 2'd3
  } evt_class_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int NUM_EVT = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] raw_in,
  input  logic [NUM_EVT-1:0] cfg_rise,
  output logic [NUM_EVT-1:0] lvl,
  output logic [NUM_EVT-1:0] edge_hit
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][NUM_EVT-1:0] chain_q, chain_d;
  logic [NUM_EVT-1:0]             prev_q, prev_d;

  // next-state
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], raw_in};
    prev_d  = chain_q[LAST];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl      = chain_q[LAST];
  assign edge_hit = (cfg_rise & lvl & ~prev_q) | (~cfg_rise & ~lvl & prev_q);
endmodule

// File: rtl/wake_evt_cell.sv
module wake_evt_cell
  import wake_pkg::*;
#(
  parameter evt_class_e CLS = EVT_LATCH_PWR
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic edge_hit,
  input  logic rd_stb,
  output logic stat,
  output logic pwr_term
);
  localparam logic USE_LATCH  = (CLS == EVT_LATCH_PWR) || (CLS == EVT_LATCH_ONLY);
  localparam logic FEED_LATCH = (CLS == EVT_LATCH_PWR);
  localparam logic USE_LEVEL  = (CLS == EVT_LEVEL);

  logic latch_q, latch_d;

  // next-state: a new edge outranks the clearing read
  always_comb begin
    latch_d = latch_q;
    if (rd_stb)   latch_d = 1'b0;
    if (edge_hit) latch_d = 1'b1;
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= 1'b0;
    else        latch_q <= latch_d;
  end

  assign stat     = (latch_q & USE_LATCH)  | (lvl & USE_LEVEL);
  assign pwr_term = (latch_q & FEED_LATCH) | (lvl & USE_LEVEL);

  generate
    if (USE_LATCH) begin : g_chk
      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> stat);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !rd_stb) |=> stat);
      assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !edge_hit) |=> !stat);
      assert_edge_beats_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && edge_hit) |=> stat);
    end
  endgenerate
endmodule

// File: rtl/wake_pwr_or.sv
module wake_pwr_or #(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] term,
  input  logic [NUM_EVT-1:0] en,
  output logic               req
);
  logic req_q, req_d;

  always_comb req_d = |(term & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign req = req_q;
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wake_pkg::*;
#(
  parameter int                   NUM_EVT     = 8,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [2*NUM_EVT-1:0] CLASS_MAP   = 16'h1FA5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic [NUM_EVT-1:0] cfg_rise,
  input  logic [NUM_EVT-1:0] cfg_pwr_en,
  input  logic               rd_stb,
  output logic [NUM_EVT-1:0] status,
  output logic               pwr_on_req
);
  function automatic logic [NUM_EVT-1:0] wake_mask(input logic [2*NUM_EVT-1:0] map);
    logic [NUM_EVT-1:0] m;
    for (int k = 0; k < NUM_EVT; k++)
      m[k] = (map[2*k +: 2] == EVT_LATCH_PWR) || (map[2*k +: 2] == EVT_LEVEL);
    return m;
  endfunction

  localparam logic [NUM_EVT-1:0] WAKE_MASK = wake_mask(CLASS_MAP);

  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [NUM_EVT-1:0] lvl, edge_hit, pwr_term;

  wake_sync #(.NUM_EVT(NUM_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .raw_in   (evt_in),
    .cfg_rise (cfg_rise),
    .lvl      (lvl),
    .edge_hit (edge_hit)
  );

  generate
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
      wake_evt_cell #(.CLS(evt_class_e'(CLASS_MAP[2*i +: 2]))) u_cell (
        .clk      (clk),
        .rst_n    (rst_sync_q),
        .lvl      (lvl[i]),
        .edge_hit (edge_hit[i]),
        .rd_stb   (rd_stb),
        .stat     (status[i]),
        .pwr_term (pwr_term[i])
      );
    end
  endgenerate

  wake_pwr_or #(.NUM_EVT(NUM_EVT)) u_or (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .term  (pwr_term),
    .en    (cfg_pwr_en),
    .req   (pwr_on_req)
  );

  assert_pwr_follows_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    1'b1 |=> (pwr_on_req == $past(|(status & WAKE_MASK & cfg_pwr_en))));
  assert_no_stray_wake_R6: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ((status & WAKE_MASK & cfg_pwr_en) == '0) |=> !pwr_on_req);
endmodule

// File: tb/wake_event_ctrl_test.sv
module wake_event_ctrl_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] evt_in, cfg_rise, cfg_pwr_en, status;
  logic         rd_stb, pwr_on_req;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  wake_event_ctrl uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg_rise(cfg_rise),
    .cfg_pwr_en(cfg_pwr_en), .rd_stb(rd_stb), .status(status),
    .pwr_on_req(pwr_on_req)
  );

  // classes: ev0,ev1,ev6 = 1; ev2,ev3 = 2; ev4,ev5 = 3; ev7 = 0
  // entry: {evt_in[8], read_first, exp_status[8], exp_pwr}
  localparam int NV = 17;
  localparam logic [17:0] VEC [NV] = '{
    {8'h00, 1'b0, 8'h00, 1'b0},  // R1 idle
    {8'h01, 1'b0, 8'h01, 1'b1},  // R2 R8 ev0 rise
    {8'h00, 1'b0, 8'h01, 1'b1},  // R2 sticky
    {8'h00, 1'b1, 8'h00, 1'b0},  // R3 read clears
    {8'h04, 1'b0, 8'h04, 1'b1},  // R5 level
    {8'h04, 1'b1, 8'h04, 1'b1},  // R5 read ignored
    {8'h00, 1'b0, 8'h00, 1'b0},  // R5 cleared at source
    {8'h10, 1'b0, 8'h10, 1'b0},  // R6 class 3 no wake
    {8'h10, 1'b1, 8'h00, 1'b0},  // R3 class 3 cleared
    {8'h00, 1'b0, 8'h00, 1'b0},  // R7 idle
    {8'h02, 1'b0, 8'h00, 1'b0},  // R7 rise ignored on falling config
    {8'h00, 1'b0, 8'h02, 1'b1},  // R7 falling captured
    {8'h40, 1'b1, 8'h40, 1'b0},  // R9 disabled wake
    {8'h80, 1'b0, 8'h40, 1'b0},  // R10 unused reads 0
    {8'h08, 1'b1, 8'h08, 1'b1},  // R5 level ev3
    {8'hFF, 1'b1, 8'h7D, 1'b1},  // R2 R10 many at once
    {8'h00, 1'b1, 8'h02, 1'b1}   // R7 ev1 fall
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_pulse();
    rd_stb = 1'b1;
    wait_neg(1);
    rd_stb = 1'b0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  initial begin
    rst_n = 1'b0; evt_in = '0; rd_stb = 1'b0;
    cfg_rise = 8'hFD; cfg_pwr_en = 8'hBF;
    wait_neg(3);
    chk("R1 status in reset", status, 8'h00);
    chk("R1 pwr in reset", {7'd0, pwr_on_req}, 8'h00);
    rst_n = 1'b1;
    wait_neg(5);
    chk("R1 status after reset", status, 8'h00);
    chk("R1 pwr after reset", {7'd0, pwr_on_req}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][9]) read_pulse();
      evt_in = VEC[v][17:10];
      wait_neg(5);
      chk($sformatf("R2-table vec %0d status", v), status, VEC[v][8:1]);
      chk($sformatf("R8 vec %0d pwr", v), {7'd0, pwr_on_req}, {7'd0, VEC[v][0]});
    end

    // clean slate
    evt_in = '0;
    read_pulse();
    wait_neg(5);
    chk("R3 all cleared", status, 8'h00);

    // latency of capture and request
    evt_in = 8'h01;
    wait_neg(2);
    chk("R2 not yet after two edges", status, 8'h00);
    wait_neg(1);
    chk("R2 set after three edges", status, 8'h01);
    chk("R8 pwr not yet", {7'd0, pwr_on_req}, 8'h00);
    wait_neg(1);
    chk("R8 pwr one edge later", {7'd0, pwr_on_req}, 8'h01);

    // edge lands in the read cycle
    evt_in = 8'h00;
    wait_neg(5);
    chk("R2 ev0 still held", status, 8'h01);
    evt_in = 8'h01;
    wait_neg(2);
    read_pulse();
    chk("R4 edge survives read", status, 8'h01);
    read_pulse();
    wait_neg(1);
    chk("R3 plain read clears", status, 8'h00);

    // reset in the middle of activity
    evt_in = 8'h14;
    wait_neg(5);
    chk("R6 class 3 with level", status, 8'h14);
    rst_n = 1'b0;
    #2;
    chk("R1 async reset status", status, 8'h00);
    chk("R1 async reset pwr", {7'd0, pwr_on_req}, 8'h00);
    evt_in = 8'h00;
    wait_neg(2);
    rst_n = 1'b1;
    wait_neg(5);
    chk("R1 status after second reset", status, 8'h00);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule